// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside the fetch path of a program sequencer and repeats a range of instructions a set number of times. The sequencer does not spend a branch instruction or a counter update on it. Every cycle the sequencer shows the block the current fetch address. The block returns the address to fetch next. That is either the following address or, at the end of a loop body, the first address of the body.

A loop-setup command arrives with the fetch address of the command itself, an iteration count and a body length. The body begins at the address after the command and ends at that address plus the length minus one. The block stores the body's first address, last address and remaining count as an entry on a small stack, so loops can nest. The end-of-body compare and the count decrement happen in the same cycle as the redirect, so the loop runs without bubbles.

Top module: `hw_loop_ctrl`

## Requirements
- R1: After reset, with no setup command, `nextPc` equals `pc + 1` and both `loopActive` and `overflow` are low.
- R2: A setup command with a nonzero count and a stack that is not full pushes a loop whose body runs from `pc + 1` to `pc + setupLen`. In that cycle `nextPc` is `pc + 1`, and `loopActive` is high from the next cycle on.
- R3: When `pc` equals the last address of the innermost loop and more than one pass remains, `nextPc` is that loop's first address in the same cycle, and one pass is taken off its count.
- R4: A loop set up with count N runs its body exactly N times. On the final pass, `nextPc` at the last address is that address plus one and the loop's entry is removed.
- R5: A setup command with count zero pushes nothing and gives `nextPc = pc + setupLen + 1`, which skips the body. This holds even when the stack is full.
- R6: With 4 loops held, a setup command with a nonzero count is dropped and `nextPc` is `pc + 1`. It sets `overflow`, which stays high until reset, and the held loops keep running unchanged.
- R7: When the innermost loop finishes at an address that is also the last address of the loop one level out, that outer loop's end test is applied in the same cycle. If more than one pass remains there, `nextPc` is the outer first address and the outer count drops by one. Otherwise both entries are removed and `nextPc` is `pc + 1`. Loops further out are not tested in that cycle.
- R8: A setup command takes priority over the end test: in a cycle with `setupValid` high, the innermost loop's end compare is not applied.
- R9: Only the innermost loop's last address is compared. A fetch at any other address, including the last address of an outer loop while an inner loop is live, gives `nextPc = pc + 1`.
- R10: A synchronous active-high reset empties the stack and clears `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc | input | 16 | Current fetch address |
| setupValid | input | 1 | The instruction at `pc` is a loop-setup command |
| setupCount | input | 16 | Iteration count of the setup command |
| setupLen | input | 16 | Body length in instructions (at least 1) |
| nextPc | output | 16 | Address to fetch next |
| loopActive | output | 1 | At least one loop is held |
| overflow | output | 1 | Sticky flag: a setup command was dropped because the stack was full |

## Verification
The bench builds the block with its defaults: 16-bit addresses and counts, and a stack of 4 entries. The shallow stack means a short burst of nested setups reaches the full condition. Counts of zero to three and body lengths of one to four are used, so loop ends coincide often and both the single-level and the two-level release paths occur in a few thousand cycles. Each fetch address the bench drives is the next address predicted by its own model. Any divergence between the block and that model therefore shows up at once as a wrong `nextPc`.

// File: rtl/hw_loop_pkg.sv
package hw_loop_pkg;
  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_TOP  = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_SKIP = 2'd3
  } nextSel_e;

  typedef struct packed {
    logic     push;
    logic     popOne;
    logic     popTwo;
    logic     decTop;
    logic     decSec;
    logic     setOvf;
    nextSel_e sel;
  } loopStrobe_t;
endpackage

// File: rtl/hw_loop_dp.sv
module hw_loop_dp
  import hw_loop_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  pc,
  input  logic [CNT_W-1:0] setupCount,
  input  logic [PC_W-1:0]  setupLen,
  input  loopStrobe_t      strb,
  output logic [PC_W-1:0]  nextPc,
  output logic [PC_W-1:0]  topEnd,
  output logic [CNT_W-1:0] topCount,
  output logic [PC_W-1:0]  secEnd,
  output logic [CNT_W-1:0] secCount,
  output logic             hasOne,
  output logic             hasTwo,
  output logic             stackFull,
  output logic             overflowQ
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0]  sp;
  logic [IDX_W-1:0] topIdx, secIdx;
  logic [PC_W-1:0]  startQ [DEPTH];
  logic [PC_W-1:0]  endQ   [DEPTH];
  logic [CNT_W-1:0] cntQ   [DEPTH];

  assign topIdx    = IDX_W'(sp - SP_W'(1));
  assign secIdx    = IDX_W'(sp - SP_W'(2));
  assign hasOne    = (sp >= SP_W'(1));
  assign hasTwo    = (sp >= SP_W'(2));
  assign stackFull = (sp == SP_W'(DEPTH));
  assign topEnd    = endQ[topIdx];
  assign topCount  = cntQ[topIdx];
  assign secEnd    = endQ[secIdx];
  assign secCount  = cntQ[secIdx];

  always_ff @(posedge clk) begin
    if (rst)              sp <= '0;
    else if (strb.push)   sp <= sp + SP_W'(1);
    else if (strb.popTwo) sp <= sp - SP_W'(2);
    else if (strb.popOne) sp <= sp - SP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)              overflowQ <= 1'b0;
    else if (strb.setOvf) overflowQ <= 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strb.push && sp == SP_W'(i)) begin
        startQ[i] <= pc + PC_W'(1);
        endQ[i]   <= pc + setupLen;
        cntQ[i]   <= setupCount;
      end else if (strb.decTop && topIdx == IDX_W'(i)) begin
        cntQ[i] <= cntQ[i] - CNT_W'(1);
      end else if (strb.decSec && secIdx == IDX_W'(i)) begin
        cntQ[i] <= cntQ[i] - CNT_W'(1);
      end
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_TOP:  nextPc = startQ[topIdx];
      SEL_SEC:  nextPc = startQ[secIdx];
      SEL_SKIP: nextPc = pc + setupLen + PC_W'(1);
      default:  nextPc = pc + PC_W'(1);
    endcase
  end
endmodule

// File: rtl/hw_loop_ctl.sv
module hw_loop_ctl
  import hw_loop_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             setupValid,
  input  logic [CNT_W-1:0] setupCount,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  topEnd,
  input  logic [CNT_W-1:0] topCount,
  input  logic [PC_W-1:0]  secEnd,
  input  logic [CNT_W-1:0] secCount,
  input  logic             hasOne,
  input  logic             hasTwo,
  input  logic             stackFull,
  output loopStrobe_t      strb
);
  always_comb begin
    strb     = '0;
    strb.sel = SEL_SEQ;
    if (setupValid) begin
      if (setupCount == '0)  strb.sel    = SEL_SKIP;
      else if (stackFull)    strb.setOvf = 1'b1;
      else                   strb.push   = 1'b1;
    end else if (hasOne && pc == topEnd) begin
      if (topCount > CNT_W'(1)) begin
        strb.decTop = 1'b1;
        strb.sel    = SEL_TOP;
      end else if (hasTwo && pc == secEnd) begin
        if (secCount > CNT_W'(1)) begin
          strb.popOne = 1'b1;
          strb.decSec = 1'b1;
          strb.sel    = SEL_SEC;
        end else begin
          strb.popTwo = 1'b1;
        end
      end else begin
        strb.popOne = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hw_loop_ctrl.sv
module hw_loop_ctrl
  import hw_loop_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  pc,
  input  logic             setupValid,
  input  logic [CNT_W-1:0] setupCount,
  input  logic [PC_W-1:0]  setupLen,
  output logic [PC_W-1:0]  nextPc,
  output logic             loopActive,
  output logic             overflow
);
  loopStrobe_t      strb;
  logic [PC_W-1:0]  topEnd, secEnd;
  logic [CNT_W-1:0] topCount, secCount;
  logic             hasOne, hasTwo, stackFull;

  hw_loop_ctl #(.PC_W(PC_W), .CNT_W(CNT_W)) u_ctl (
    .setupValid(setupValid), .setupCount(setupCount), .pc(pc),
    .topEnd(topEnd), .topCount(topCount), .secEnd(secEnd), .secCount(secCount),
    .hasOne(hasOne), .hasTwo(hasTwo), .stackFull(stackFull), .strb(strb)
  );

  hw_loop_dp #(.PC_W(PC_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .pc(pc), .setupCount(setupCount), .setupLen(setupLen),
    .strb(strb), .nextPc(nextPc), .topEnd(topEnd), .topCount(topCount),
    .secEnd(secEnd), .secCount(secCount), .hasOne(hasOne), .hasTwo(hasTwo),
    .stackFull(stackFull), .overflowQ(overflow)
  );

  assign loopActive = hasOne;
endmodule

// File: rtl/hw_loop_ctrl_chk.sv
module hw_loop_ctrl_chk #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [PC_W-1:0]  pc,
  input logic             setupValid,
  input logic [CNT_W-1:0] setupCount,
  input logic [PC_W-1:0]  setupLen,
  input logic [PC_W-1:0]  nextPc,
  input logic             loopActive,
  input logic             overflow
);
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!loopActive && !overflow));

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_overflow_cause_r6: assert property (@(posedge clk) disable iff (rst)
    !overflow ##1 overflow |-> $past(setupValid && loopActive && setupCount != '0));

  p_setup_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (setupValid && setupCount != '0) |-> nextPc == pc + PC_W'(1));

  p_push_active_r2: assert property (@(posedge clk) disable iff (rst)
    (setupValid && setupCount != '0 && !loopActive) |=> loopActive);

  p_zero_skip_r5: assert property (@(posedge clk) disable iff (rst)
    (setupValid && setupCount == '0) |-> nextPc == pc + setupLen + PC_W'(1));

  p_idle_seq_r1: assert property (@(posedge clk) disable iff (rst)
    (!loopActive && !setupValid) |-> nextPc == pc + PC_W'(1));
endmodule

bind hw_loop_ctrl hw_loop_ctrl_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_hw_loop_ctrl.sv
module tb_hw_loop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pc = '0;
  logic        setupValid = 1'b0;
  logic [15:0] setupCount = '0;
  logic [15:0] setupLen = 16'd1;
  logic [15:0] nextPc;
  logic        loopActive, overflow;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] mStart [DEPTH];
  logic [15:0] mEnd   [DEPTH];
  logic [15:0] mCnt   [DEPTH];
  int          mSp  = 0;
  logic        mOvf = 1'b0;
  logic [15:0] curPc = 16'h0100;
  string       forceTag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_loop_ctrl dut (
    .clk(clk), .rst(rst), .pc(pc), .setupValid(setupValid),
    .setupCount(setupCount), .setupLen(setupLen), .nextPc(nextPc),
    .loopActive(loopActive), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; setupValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mSp = 0; mOvf = 1'b0;
    chk(loopActive == 1'b0, "R10 loopActive", {15'd0, loopActive}, 16'd0);
    chk(overflow == 1'b0, "R10 overflow", {15'd0, overflow}, 16'd0);
  endtask

  task automatic step(input logic sv, input logic [15:0] cnt, input logic [15:0] len);
    logic [15:0] exp;
    string tag;
    bit doPush, doPop1, doPop2, decT, decS, doOvf;
    int t, s;
    doPush = 0; doPop1 = 0; doPop2 = 0; decT = 0; decS = 0; doOvf = 0;
    @(negedge clk);
    pc = curPc; setupValid = sv; setupCount = cnt; setupLen = len;
    #1;
    exp = curPc + 16'd1;
    tag = "R9 sequential";
    t = mSp - 1; s = mSp - 2;
    if (sv) begin
      if (cnt == 16'd0) begin exp = curPc + len + 16'd1; tag = "R5 zero-count skip"; end
      else if (mSp == DEPTH) begin doOvf = 1; tag = "R6 full stack"; end
      else begin doPush = 1; tag = "R2 setup"; end
      if (mSp > 0 && curPc == mEnd[t] && cnt != 16'd0) tag = "R8 setup priority";
    end else if (mSp > 0 && curPc == mEnd[t]) begin
      if (mCnt[t] > 16'd1) begin
        decT = 1; exp = mStart[t]; tag = "R3 loop back";
      end else if (mSp > 1 && curPc == mEnd[s]) begin
        if (mCnt[s] > 16'd1) begin doPop1 = 1; decS = 1; exp = mStart[s]; tag = "R7 outer loop back"; end
        else begin doPop2 = 1; tag = "R7 double exit"; end
      end else begin
        doPop1 = 1; tag = "R4 loop exit";
      end
    end
    if (forceTag != "") tag = forceTag;
    chk(nextPc == exp, tag, nextPc, exp);
    chk(loopActive == (mSp != 0), {tag, " loopActive"}, {15'd0, loopActive}, {15'd0, mSp != 0});
    chk(overflow == mOvf, {tag, " R6 overflow"}, {15'd0, overflow}, {15'd0, mOvf});
    @(posedge clk);
    if (doPush) begin
      mStart[mSp] = curPc + 16'd1; mEnd[mSp] = curPc + len; mCnt[mSp] = cnt; mSp++;
    end
    if (decT) mCnt[t] = mCnt[t] - 16'd1;
    if (decS) mCnt[s] = mCnt[s] - 16'd1;
    if (doPop1) mSp -= 1;
    if (doPop2) mSp -= 2;
    if (doOvf) mOvf = 1'b1;
    curPc = exp;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    doReset();
    forceTag = "R1 idle after reset";
    for (int i = 0; i < 3; i++) step(1'b0, 16'd0, 16'd1);
    forceTag = "";

    // Single loop, count 3, body of 2: R2, R3, R4
    step(1'b1, 16'd3, 16'd2);
    for (int i = 0; i < 8; i++) step(1'b0, 16'd0, 16'd1);

    // Zero count skips the body: R5
    step(1'b1, 16'd0, 16'd5);
    step(1'b0, 16'd0, 16'd1);

    // Coincident ends, outer count 2, inner count 2: R7
    step(1'b1, 16'd2, 16'd3);
    step(1'b1, 16'd2, 16'd2);
    for (int i = 0; i < 14; i++) step(1'b0, 16'd0, 16'd1);

    // Fill the stack, then one more setup: R6
    step(1'b1, 16'd2, 16'd12);
    step(1'b1, 16'd2, 16'd10);
    step(1'b1, 16'd2, 16'd8);
    step(1'b1, 16'd2, 16'd6);
    step(1'b1, 16'd3, 16'd2);
    step(1'b1, 16'd0, 16'd1);
    for (int i = 0; i < 120; i++) step(1'b0, 16'd0, 16'd1);

    // Reset mid-run: R10
    doReset();

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic sv;
      sv = ($urandom % 6) == 0;
      step(sv, 16'($urandom % 4), 16'(1 + $urandom % 4));
      if (i == 2000) doReset();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule